// File: doc/BRIEF.md
# MDIO management access controller

This block is a register-driven management master for clause-22 PHY registers. Software first loads a 16-bit data register, then writes a command word that carries the PHY address, the register number, a management-clock select, a write flag and a busy flag. Setting the busy flag launches one serial management frame on the MDC/MDIO pair. When a read frame ends, the returned 16 bits sit in the data register. The busy flag stays set for the whole frame and clears when it completes, so software polls that flag to find the end.

The block also carries a PHY discovery scan. A one-cycle start pulse makes it walk the PHY addresses upward. At each address it reads the first identifier register and compares it with the upper half of an expected 32-bit identifier. Only when that matches does it read the second identifier register, whose low revision nibble is left out of the comparison. The scan stops at the first hit and reports the address. If it finds no hit, it repeats whole passes until a configurable timeout runs out and then raises a fail flag. A timeout of zero gives exactly one pass. The scan takes its management clock from the bus-clock frequency band set by a parameter.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset the data and command read-back words are 0, `mdc` is low, `mdio_oe` is low, and `scan_hit` and `scan_fail` are 0.
- R2: The command word is laid out as PHY address [15:11], register number [10:6], clock select [5:2], write flag [1] and busy [0]. Writing it while idle with bit 0 set starts a frame, and `cmd_rdata[0]` reads 1 from the next cycle until the frame ends.
- R3: Each frame is 64 MDC periods, sent MSB first: 32 ones, start bits 0 then 1, opcode 1,0 for a read or 0,1 for a write, 5-bit PHY address, 5-bit register number, two turnaround bits and 16 data bits. In a write frame the master drives the turnaround as 1 then 0.
- R4: In a read frame the master releases MDIO (`mdio_oe` low) from the first turnaround bit to the end of the frame. It samples the 16 data bits on MDC rising edges into the data register. An address with no PHY reads back 16'hFFFF through the pull-up.
- R5: A write frame carries the data register contents, and the write leaves the data register unchanged.
- R6: Clock select 1 gives an MDC period of 26 bus clocks, 2 gives 16, and 0 or any value from 3 to 15 gives 42. MDC is low while idle, and MDIO changes only after an MDC falling edge.
- R7: While busy, command writes, data writes and scan start pulses are all ignored.
- R8: The scan visits addresses 0 to 30 in ascending order and reads register 2 at each. It reads register 3 only when register 2 equals the upper 16 bits of `scan_id`, and compares register 3 with the lower 16 bits while ignoring bits [3:0]. On the first hit it raises `scan_hit` and reports the address on `scan_addr`.
- R9: The scan never tries address 31. When a pass finds no hit and the timeout has run out (or is zero), `scan_fail` rises; otherwise a new pass starts at address 0.
- R10: The scan MDC period is 42 bus clocks for `BUS_CLK_MHZ` of 60 or more, 26 for 35 or more, and 16 below that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| data_we | input | 1 | Data register write strobe |
| data_wdata | input | 16 | Data register write value |
| cmd_we | input | 1 | Command register write strobe |
| cmd_wdata | input | 16 | Command word |
| data_rdata | output | 16 | Data register read-back |
| cmd_rdata | output | 16 | Command read-back with live busy in bit 0 |
| scan_go | input | 1 | Discovery scan start pulse |
| scan_id | input | 32 | Expected PHY identifier |
| scan_hit | output | 1 | Scan found a match |
| scan_fail | output | 1 | Scan gave up without a match |
| scan_addr | output | 5 | Address of the last address tried, or of the match |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO line as seen at the pad |
| mdio_o | output | 1 | MDIO drive value |
| mdio_oe | output | 1 | MDIO drive enable |

## Verification
The bench goes after the read turnaround. If the master kept driving MDIO there, the bench PHY's data would never reach the data register and reads would return the master's own ones. It also checks the revision-nibble mask at its edge: a mismatch in bit 4 must fail while one in bits 3:0 must hit. A mask set one bit too wide or too narrow swaps those two outcomes. The scan's short-circuit order and its last address are checked by counting the identifier reads the PHY model receives. A scan that read register 3 unconditionally, or that tried address 31, would change those counts or find a PHY it must not see. Commands issued mid-frame must leave the fields, the data and the frame count untouched, since a design that accepted them would corrupt or restart the frame in flight.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  localparam int FRAME_BITS = 64;
  localparam int TA_POS     = 46;   // first turnaround bit index
  localparam int DATA_POS   = 48;   // first data bit index

  typedef struct packed {
    logic [4:0] phy;
    logic [4:0] regn;
    logic [3:0] csel;
    logic       wr;
  } mdio_cmd_t;

  typedef enum logic [2:0] {
    SC_IDLE, SC_ISSUE1, SC_WAIT1, SC_ISSUE2, SC_WAIT2
  } scan_state_e;

  // half MDC period in bus clocks for a clock-select code
  function automatic logic [5:0] half_period(input logic [3:0] sel);
    case (sel)
      4'd1:    return 6'd13;
      4'd2:    return 6'd8;
      default: return 6'd21;
    endcase
  endfunction

  // clock-select code for a bus frequency band (MHz)
  function automatic logic [3:0] sel_for_mhz(input int unsigned mhz);
    if (mhz >= 60)      return 4'd0;
    else if (mhz >= 35) return 4'd1;
    else                return 4'd2;
  endfunction

  // the 64-bit serial frame, bit 63 goes out first
  function automatic logic [63:0] frame_word(input mdio_cmd_t c, input logic [15:0] wdata);
    return {32'hFFFF_FFFF, 2'b01, (c.wr ? 2'b01 : 2'b10), c.phy, c.regn,
            (c.wr ? 2'b10 : 2'b11), (c.wr ? wdata : 16'hFFFF)};
  endfunction

  function automatic logic id_hi_match(input logic [15:0] rd, input logic [31:0] id);
    return rd == id[31:16];
  endfunction

  function automatic logic id_lo_match(input logic [15:0] rd, input logic [31:0] id);
    return (rd & 16'hFFF0) == (id[15:0] & 16'hFFF0);
  endfunction

endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] half,
  output logic          mdc,
  output logic          rise,
  output logic          fall
);
  logic [CW-1:0] cnt;
  logic          mdc_q;
  logic          tick;

  assign tick = run && (cnt == half - CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt   <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt   <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  assign rise = tick && !mdc_q;
  assign fall = tick &&  mdc_q;
  assign mdc  = mdc_q;
endmodule

// File: rtl/mdio_shift.sv
module mdio_shift
  import mdio_mgmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  mdio_cmd_t   cmd,
  input  logic [15:0] wdata,
  input  logic        rise,
  input  logic        fall,
  input  logic        mdio_i,
  output logic        active,
  output logic        done,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic [15:0] rdata
);
  logic [FRAME_BITS-1:0] frame_q;
  logic [5:0]            idx;
  logic                  wr_q;
  logic [15:0]           shin;
  logic                  last_bit;

  assign last_bit = (idx == 6'(FRAME_BITS - 1));
  assign done     = active && fall && last_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_q <= '0;
      idx     <= '0;
      active  <= 1'b0;
      wr_q    <= 1'b0;
      shin    <= '0;
    end else if (start) begin
      frame_q <= frame_word(cmd, wdata);
      idx     <= '0;
      active  <= 1'b1;
      wr_q    <= cmd.wr;
    end else if (active) begin
      if (rise && !wr_q && idx >= 6'(DATA_POS))
        shin <= {shin[14:0], mdio_i};
      if (fall) begin
        if (last_bit) active <= 1'b0;
        else          idx    <= idx + 6'd1;
      end
    end
  end

  assign mdio_o  = active ? frame_q[6'(FRAME_BITS - 1) - idx] : 1'b1;
  assign mdio_oe = active && (wr_q || idx < 6'(TA_POS));
  assign rdata   = shin;
endmodule

// File: rtl/mdio_scan.sv
module mdio_scan
  import mdio_mgmt_pkg::*;
#(
  parameter logic [4:0]  ID1_REG   = 5'd2,
  parameter logic [4:0]  ID2_REG   = 5'd3,
  parameter logic [4:0]  LAST_ADDR = 5'd30,
  parameter int unsigned TO_CYC    = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic [31:0] target_id,
  input  logic        txn_done,
  input  logic [15:0] rdata,
  output logic        req,
  output logic [4:0]  req_reg,
  output logic        busy,
  output logic        hit,
  output logic        fail,
  output logic [4:0]  addr
);
  scan_state_e st;
  logic [31:0] id_q;
  logic [31:0] timer;
  logic        expired;
  logic        miss;
  logic        matched;

  assign matched = txn_done && st == SC_WAIT2 && id_lo_match(rdata, id_q);
  assign miss    = txn_done && ((st == SC_WAIT1 && !id_hi_match(rdata, id_q)) ||
                                (st == SC_WAIT2 && !id_lo_match(rdata, id_q)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= SC_IDLE;
      id_q    <= '0;
      timer   <= '0;
      expired <= 1'b0;
      hit     <= 1'b0;
      fail    <= 1'b0;
      addr    <= '0;
    end else begin
      if (st != SC_IDLE && !expired) begin
        timer <= timer + 32'd1;
        if (timer >= TO_CYC - 32'd1) expired <= 1'b1;
      end
      case (st)
        SC_IDLE: if (go) begin
          st      <= SC_ISSUE1;
          id_q    <= target_id;
          addr    <= '0;
          hit     <= 1'b0;
          fail    <= 1'b0;
          timer   <= '0;
          expired <= (TO_CYC == 0);
        end
        SC_ISSUE1: st <= SC_WAIT1;
        SC_ISSUE2: st <= SC_WAIT2;
        default: begin
          if (matched) begin
            hit <= 1'b1;
            st  <= SC_IDLE;
          end else if (miss) begin
            if (addr != LAST_ADDR) begin
              addr <= addr + 5'd1;
              st   <= SC_ISSUE1;
            end else if (expired) begin
              fail <= 1'b1;
              st   <= SC_IDLE;
            end else begin
              addr <= '0;
              st   <= SC_ISSUE1;
            end
          end else if (txn_done) begin
            st <= SC_ISSUE2;   // first ID register matched
          end
        end
      endcase
    end
  end

  assign req     = (st == SC_ISSUE1) || (st == SC_ISSUE2);
  assign req_reg = (st == SC_ISSUE1 || st == SC_WAIT1) ? ID1_REG : ID2_REG;
  assign busy    = (st != SC_IDLE);
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int unsigned BUS_CLK_MHZ     = 72,
  parameter int unsigned SCAN_TIMEOUT_MS = 100,
  parameter logic [4:0]  ID1_REG         = 5'd2,
  parameter logic [4:0]  ID2_REG         = 5'd3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        data_we,
  input  logic [15:0] data_wdata,
  input  logic        cmd_we,
  input  logic [15:0] cmd_wdata,
  output logic [15:0] data_rdata,
  output logic [15:0] cmd_rdata,
  input  logic        scan_go,
  input  logic [31:0] scan_id,
  output logic        scan_hit,
  output logic        scan_fail,
  output logic [4:0]  scan_addr,
  output logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe
);
  localparam logic [3:0]  SCAN_SEL = sel_for_mhz(BUS_CLK_MHZ);
  localparam int unsigned TO_CYC   = SCAN_TIMEOUT_MS * BUS_CLK_MHZ * 1000;

  mdio_cmd_t   cmd_q, cmd_in, scan_cmd, eng_cmd;
  logic [15:0] data_q;
  logic [5:0]  half_q;
  logic        sw_txn_q;

  // named internal events
  logic        busy, sw_start, txn_start, txn_done, mdc_rise, mdc_fall;
  logic        eng_active, scan_busy, scan_req, scan_go_ok;
  logic [4:0]  scan_reg;
  logic [15:0] eng_rdata;

  assign cmd_in     = {cmd_wdata[15:11], cmd_wdata[10:6], cmd_wdata[5:2], cmd_wdata[1]};
  assign scan_cmd   = {scan_addr, scan_reg, SCAN_SEL, 1'b0};
  assign eng_cmd    = scan_busy ? scan_cmd : cmd_in;
  assign busy       = eng_active || scan_busy;
  assign sw_start   = cmd_we && cmd_wdata[0] && !busy;
  assign scan_go_ok = scan_go && !busy && !sw_start;
  assign txn_start  = sw_start || scan_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      data_q   <= '0;
      half_q   <= 6'd21;
      sw_txn_q <= 1'b0;
    end else begin
      if (cmd_we && !busy) cmd_q <= cmd_in;
      if (txn_start) begin
        half_q   <= half_period(eng_cmd.csel);
        sw_txn_q <= !scan_busy;
      end
      if (data_we && !busy)
        data_q <= data_wdata;
      else if (txn_done && sw_txn_q && !cmd_q.wr)
        data_q <= eng_rdata;
    end
  end

  mdio_clk_gen #(.CW(6)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(eng_active), .half(half_q),
    .mdc(mdc), .rise(mdc_rise), .fall(mdc_fall)
  );

  mdio_shift u_shift (
    .clk(clk), .rst_n(rst_n), .start(txn_start), .cmd(eng_cmd), .wdata(data_q),
    .rise(mdc_rise), .fall(mdc_fall), .mdio_i(mdio_i),
    .active(eng_active), .done(txn_done), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .rdata(eng_rdata)
  );

  mdio_scan #(
    .ID1_REG(ID1_REG), .ID2_REG(ID2_REG), .LAST_ADDR(5'd30), .TO_CYC(TO_CYC)
  ) u_scan (
    .clk(clk), .rst_n(rst_n), .go(scan_go_ok), .target_id(scan_id),
    .txn_done(txn_done), .rdata(eng_rdata), .req(scan_req), .req_reg(scan_reg),
    .busy(scan_busy), .hit(scan_hit), .fail(scan_fail), .addr(scan_addr)
  );

  assign data_rdata = data_q;
  assign cmd_rdata  = {cmd_q.phy, cmd_q.regn, cmd_q.csel, cmd_q.wr, busy};
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        sw_start,
  input logic        txn_start,
  input logic        txn_done,
  input logic        mdc_fall,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        cmd_we,
  input logic        data_we,
  input logic [15:0] cmd_rdata,
  input logic [15:0] data_rdata,
  input logic        scan_hit,
  input logic        scan_fail
);
  // R2: busy holds until the frame-done event
  p_busy_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !txn_done |=> busy);

  // R2: an accepted start shows busy in the read-back next cycle
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sw_start |=> cmd_rdata[0]);

  // R6: MDC rests low when idle
  p_mdc_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  // R6: MDIO moves only after an MDC falling edge (or at frame launch)
  p_out_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !mdc_fall && !txn_start |=> $stable(mdio_o) && $stable(mdio_oe));

  // R4: MDIO is driven only inside a frame
  p_oe_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> busy);

  // R7: command writes while busy leave the fields alone
  p_cmd_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cmd_we |=> $stable(cmd_rdata[15:1]));

  // R7: data writes while busy leave the data register alone
  p_data_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && data_we && !txn_done |=> $stable(data_rdata));

  // R8/R9: hit and fail never both set
  p_scan_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(scan_hit && scan_fail));
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .sw_start(sw_start),
  .txn_start(txn_start), .txn_done(txn_done), .mdc_fall(mdc_fall), .mdc(mdc),
  .mdio_o(mdio_o), .mdio_oe(mdio_oe), .cmd_we(cmd_we), .data_we(data_we),
  .cmd_rdata(cmd_rdata), .data_rdata(data_rdata),
  .scan_hit(scan_hit), .scan_fail(scan_fail)
);

// File: tb/tb_mdio_mgmt_ctrl.sv
`timescale 1ns/1ps
module tb_mdio_mgmt_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        data_we = 1'b0, cmd_we = 1'b0, scan_go = 1'b0;
  logic [15:0] data_wdata = '0, cmd_wdata = '0;
  logic [31:0] scan_id = '0;
  logic [15:0] data_rdata, cmd_rdata;
  logic        scan_hit, scan_fail, mdc, mdio_o, mdio_oe, mdio_i;
  logic [4:0]  scan_addr;

  always #2 clk = ~clk;   // 250 MHz

  mdio_mgmt_ctrl #(.BUS_CLK_MHZ(25), .SCAN_TIMEOUT_MS(0)) dut (
    .clk(clk), .rst_n(rst_n), .data_we(data_we), .data_wdata(data_wdata),
    .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .data_rdata(data_rdata),
    .cmd_rdata(cmd_rdata), .scan_go(scan_go), .scan_id(scan_id),
    .scan_hit(scan_hit), .scan_fail(scan_fail), .scan_addr(scan_addr),
    .mdc(mdc), .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  int tests = 0, fails = 0;
  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // ---------------- PHY model ----------------
  logic [4:0]  model_addr = 5'd5;
  logic [31:0] model_id   = 32'h0022_1619;
  logic        drv_en = 1'b0, drv_val = 1'b1;
  wire         mdio_line = mdio_oe ? mdio_o : (drv_en ? drv_val : 1'b1);
  assign mdio_i = mdio_line;

  int fb = -1, ones = 0, pre = 0, frames = 0, rd2 = 0, rd3 = 0;
  logic [63:0] cap = '0;
  logic        resp = 1'b0;
  logic [15:0] rd_val = '0;
  logic [1:0]  l_op = '0, l_ta = '0, l_st = '0;
  logic [4:0]  l_phy = '0, l_reg = '0;
  logic [15:0] l_wdata = '0;
  int          l_pre = 0;

  function automatic logic [15:0] phy_reg_val(input logic [4:0] r, input logic [31:0] id);
    if (r == 5'd2) return id[31:16];
    if (r == 5'd3) return id[15:0];
    return {r, ~r, 6'h15};
  endfunction

  always @(posedge mdc) begin
    logic b;
    b = mdio_line;
    if (fb < 0) begin
      if (b) ones++;
      else begin
        if (ones >= 32) begin fb = 33; cap = '0; pre = ones; end
        ones = 0;
      end
    end else begin
      cap[63-fb] = b;
      if (fb == 45) begin
        resp = (cap[29:28] == 2'b10) && (cap[27:23] == model_addr);
        if (cap[29:28] == 2'b10 && cap[22:18] == 5'd2) rd2++;
        if (cap[29:28] == 2'b10 && cap[22:18] == 5'd3) rd3++;
        rd_val = phy_reg_val(cap[22:18], model_id);
      end
      if (fb == 46 && resp) begin drv_en = 1'b1; drv_val = 1'b0; end
      if (fb >= 47 && fb <= 62 && resp) drv_val = rd_val[62-fb];
      if (fb == 63) begin
        drv_en = 1'b0; resp = 1'b0;
        l_st = cap[31:30]; l_op = cap[29:28]; l_phy = cap[27:23]; l_reg = cap[22:18];
        l_ta = cap[17:16]; l_wdata = cap[15:0]; l_pre = pre;
        frames++; fb = -1;
      end else fb++;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sw_cmd(input logic [4:0] phy, input logic [4:0] r,
                        input logic [3:0] csel, input logic wr);
    @(negedge clk);
    cmd_wdata = {phy, r, csel, wr, 1'b1};
    cmd_we = 1'b1;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic load_data(input logic [15:0] v);
    @(negedge clk); data_wdata = v; data_we = 1'b1;
    @(negedge clk); data_we = 1'b0;
  endtask

  task automatic wait_idle(input int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (cmd_rdata[0] == 1'b0) return;
    end
  endtask

  task automatic mdc_period(output int unsigned p);
    int unsigned t0;
    @(posedge mdc); t0 = cyc;
    @(posedge mdc); p = cyc - t0;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    chk("R1 data", 32'(data_rdata), 32'h0);
    chk("R1 cmd", 32'(cmd_rdata), 32'h0);
    chk("R1 mdc/oe", {30'h0, mdc, mdio_oe}, 32'h0);
    chk("R1 scan flags", {30'h0, scan_hit, scan_fail}, 32'h0);
  endtask

  task automatic t_write;
    int f0;
    f0 = frames;
    load_data(16'hBEEF);
    sw_cmd(5'd5, 5'd9, 4'd2, 1'b1);
    chk("R2 busy after start", 32'(cmd_rdata[0]), 32'h1);
    wait_idle(3000);
    chk("R2 busy cleared", 32'(cmd_rdata[0]), 32'h0);
    chk("R3 one frame", 32'(frames - f0), 32'h1);
    chk("R3 preamble ones", 32'(l_pre), 32'd32);
    chk("R3 start/op write", {28'h0, l_st, l_op}, {28'h0, 2'b01, 2'b01});
    chk("R3 phy/reg", {22'h0, l_phy, l_reg}, {22'h0, 5'd5, 5'd9});
    chk("R3 write turnaround", 32'(l_ta), 32'h2);
    chk("R5 write data", 32'(l_wdata), 32'h0000BEEF);
    chk("R5 data kept", 32'(data_rdata), 32'h0000BEEF);
    chk("R2 cmd fields", 32'(cmd_rdata), 32'(16'b00101_01001_0010_1_0));
  endtask

  task automatic t_read;
    sw_cmd(5'd5, 5'd7, 4'd2, 1'b0);
    wait_idle(3000);
    chk("R3 op read", 32'(l_op), 32'h2);
    chk("R4 read data", 32'(data_rdata), 32'(phy_reg_val(5'd7, model_id)));
    sw_cmd(5'd12, 5'd1, 4'd2, 1'b0);
    wait_idle(3000);
    chk("R4 absent phy", 32'(data_rdata), 32'h0000FFFF);
  endtask

  task automatic t_divider;
    int unsigned p;
    sw_cmd(5'd12, 5'd1, 4'd1, 1'b0); mdc_period(p); wait_idle(5000);
    chk("R6 select 1 period", p, 32'd26);
    sw_cmd(5'd12, 5'd1, 4'd0, 1'b0); mdc_period(p); wait_idle(5000);
    chk("R6 select 0 period", p, 32'd42);
    sw_cmd(5'd12, 5'd1, 4'd9, 1'b0); mdc_period(p); wait_idle(5000);
    chk("R6 select 9 period", p, 32'd42);
    repeat (3) @(negedge clk);
    chk("R6 mdc low idle", 32'(mdc), 32'h0);
  endtask

  task automatic t_busy_ignore;
    int f0;
    f0 = frames;
    sw_cmd(5'd5, 5'd4, 4'd2, 1'b0);
    repeat (20) @(negedge clk);
    cmd_wdata = {5'd3, 5'd1, 4'd0, 1'b1, 1'b1}; cmd_we = 1'b1;
    data_wdata = 16'h1234; data_we = 1'b1; scan_go = 1'b1;
    @(negedge clk);
    cmd_we = 1'b0; data_we = 1'b0; scan_go = 1'b0;
    wait_idle(3000);
    repeat (100) @(negedge clk);
    chk("R7 cmd fields kept", 32'(cmd_rdata), 32'(16'b00101_00100_0010_0_0));
    chk("R7 data not overwritten", 32'(data_rdata), 32'(phy_reg_val(5'd4, model_id)));
    chk("R7 no extra frame", 32'(frames - f0), 32'h1);
    chk("R7 scan not started", {30'h0, scan_hit, scan_fail}, 32'h0);
  endtask

  task automatic run_scan(input logic [31:0] id, output int unsigned p);
    rd2 = 0; rd3 = 0;
    @(negedge clk); scan_id = id; scan_go = 1'b1;
    @(negedge clk); scan_go = 1'b0;
    mdc_period(p);
    wait_idle(40000);
  endtask

  task automatic t_scan_hit;
    int unsigned p;
    model_addr = 5'd5; model_id = 32'h0022_1619;
    run_scan(32'h0022_1610, p);
    chk("R10 scan mdc period", p, 32'd16);
    chk("R8 hit", {30'h0, scan_hit, scan_fail}, 32'h2);
    chk("R8 addr", 32'(scan_addr), 32'd5);
    chk("R8 id1 reads ascending", 32'(rd2), 32'd6);
    chk("R8 id2 read once", 32'(rd3), 32'd1);
  endtask

  task automatic t_scan_mask_edge;
    int unsigned p;
    model_addr = 5'd5; model_id = 32'h0022_1619;
    run_scan(32'h0022_1609, p);
    chk("R8 bit4 mismatch fails", {30'h0, scan_hit, scan_fail}, 32'h1);
    chk("R9 one pass", 32'(rd2), 32'd31);
    chk("R8 id2 read on id1 match", 32'(rd3), 32'd1);
  endtask

  task automatic t_scan_addr31;
    int unsigned p;
    model_addr = 5'd31; model_id = 32'h0022_1619;
    run_scan(32'h0022_1619, p);
    chk("R9 addr 31 not tried", {30'h0, scan_hit, scan_fail}, 32'h1);
    chk("R9 last addr", 32'(scan_addr), 32'd30);
    chk("R9 no id2 read", 32'(rd3), 32'd0);
  endtask

  // ---------------- sequence and watchdog ----------------
  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write();
    t_read();
    t_divider();
    t_busy_ignore();
    t_scan_hit();
    t_scan_mask_edge();
    t_scan_addr31();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cyc > 190000);
    tests++; fails++;
    $display("FAIL watchdog: actual cycle %0d expected end before 190000", cyc);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule